// File: doc/BRIEF.md
# Bidirectional 8-bit Timer with Twin Compare Channels

This block is a small event timer. An 8-bit count advances by one step on each qualified tick. The tick comes from one of two single-cycle enable inputs: the internal prescaled strobe or an external strobe. A two-bit mode field sets how the count runs:

- mode 0 runs up and wraps freely;
- mode 1 restarts from zero after reaching compare value A;
- mode 2 runs a single-slope PWM ramp;
- mode 3 runs a triangle that turns around at the ends.

Two compare channels watch the count on every tick. Each channel raises a sticky flag and shapes a waveform output. An overflow event raises a third flag. A per-flag mask combines the flags into a single interrupt request.

Software controls the block through a write-only register port. The port sets the control field, loads the count, writes the compare values, sets the masks, and clears flags. In the two PWM modes, compare writes land in a holding buffer. The buffer is copied into the live compare register only at a safe point of the cycle, so a duty change never produces a glitched period.

Top module: `tmr8_updown`

## Requirements
- R1: After reset the count is 0x00, all flags are clear, both waveform outputs are low and the interrupt request is low.
- R2: When the run bit (control bit 2) is 0, ticks do not move the count and raise no flag.
- R3: Control bit 3 selects the tick source: 0 takes `tick_i`, 1 takes `ext_tick_i`. The other strobe is ignored.
- R4: In mode 0 (control bits 1:0), the count steps up and wraps from 0xFF to 0x00. The overflow flag (flag bit 0) sets on the tick that leaves 0xFF. The same holds in modes 1 and 2.
- R5: In mode 1, the tick taken while the count equals compare A returns the count to 0x00.
- R6: A tick taken while the count equals a channel's live compare value sets that channel's flag (bit 1 for A, bit 2 for B). In modes 0 and 1 the same tick toggles that channel's waveform output (`wave_o[0]` for A, `wave_o[1]` for B).
- R7: After a write to the count (address 1), the next tick raises no compare match and leaves the waveforms unchanged.
- R8: Compare writes go to address 2 (A) and address 3 (B).
  - In modes 0 and 1 they take effect at once.
  - In mode 2 they are held until the tick taken at TOP (0xFF).
  - In mode 3 they are held until the tick taken at BOTTOM (0x00).
- R9: In mode 2, the tick taken at TOP sets the waveform. A compare match clears it. When both occur on the same tick, set wins.
- R10: In mode 3, the count runs up to 0xFF, turns down, runs to 0x00 and turns up again. The tick taken at 0x00 sets the overflow flag.
- R11: In mode 3, a match while counting up clears the waveform, and a match while counting down sets it.
- R12: Flags stay set until a one is written to their bit at address 5. `irq_o` is high exactly when some flag is set together with its mask bit at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Internal prescaled tick strobe |
| ext_tick_i | input | 1 | External tick strobe, already in the clock domain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 control, 1 count, 2 compare A, 3 compare B, 4 mask, 5 flag clear |
| wr_data_i | input | W | Write data |
| count_o | output | W | Current count |
| flags_o | output | 3 | Sticky flags: bit 0 overflow, bit 1 compare A, bit 2 compare B |
| wave_o | output | 2 | Waveform outputs of channels A and B |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default width of W = 8, so MAX is 0xFF. Count writes jump the counter next to the turning points, which reaches wrap, TOP, BOTTOM and the dual-slope reversals within a few ticks each instead of a full lap. This also makes the suppression rule for a count write directly observable in every scenario.

// File: rtl/tmr_pkg.sv
// Shared encodings for the up/down timer: modes, register addresses, flag bits.
// Assumes a 3-bit register address space.
package tmr_pkg;
    typedef enum logic [1:0] {
        M_NORM = 2'd0,
        M_CTC  = 2'd1,
        M_PWM1 = 2'd2,
        M_PWM2 = 2'd3
    } tmr_mode_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CNT  = 3'd1;
    localparam logic [2:0] A_CMPA = 3'd2;
    localparam logic [2:0] A_CMPB = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;
    localparam logic [2:0] A_FLAG = 3'd5;

    localparam int unsigned NFLAG = 3;
    localparam int unsigned NCH   = 2;
endpackage

// File: rtl/tmr_core.sv
// Counter engine: holds the count and the slope direction, and advances on
// the effective tick. Assumes the load and direction-reset requests never
// coincide with each other; either one blocks the tick in that cycle.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] top,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dir_rst,
    output logic [W-1:0] cnt,
    output logic         down,
    output logic         adv,
    output logic         at_top,
    output logic         at_bot,
    output logic         ovf_ev
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    // Decode the turning points and the qualified advance.
    always_comb begin
        at_top = (cnt == top);
        at_bot = (cnt == '0);
        adv    = tick && !ld && !dir_rst;
        ovf_ev = adv && ((mode == M_PWM2) ? at_bot : (cnt == MAXV));
    end

    // Count and direction register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (dir_rst) begin
            down <= 1'b0;
        end else if (adv) begin
            case (mode)
                M_NORM: cnt <= cnt + ONE;
                M_CTC, M_PWM1: cnt <= at_top ? '0 : cnt + ONE;
                default: begin
                    if (!down) begin
                        if (at_top) begin
                            down <= 1'b1;
                            cnt  <= cnt - ONE;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end else begin
                        if (at_bot) begin
                            down <= 1'b0;
                            cnt  <= cnt + ONE;
                        end else begin
                            cnt <= cnt - ONE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tmr_chan.sv
// One compare channel: holding buffer, live compare value, match detection
// and waveform shaping. Assumes adv is already qualified by the core.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         sup,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] cnt,
    input  logic         at_top,
    input  logic         at_bot,
    input  logic         down,
    input  logic         wr_buf,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] act,
    output logic         match_ev,
    output logic         wave
);
    logic [W-1:0] hold_q;
    logic         direct;
    logic         load_pt;

    // Decide whether writes are immediate and where the buffer is copied.
    always_comb begin
        direct   = (mode == M_NORM) || (mode == M_CTC);
        load_pt  = adv && (((mode == M_PWM1) && at_top) ||
                           ((mode == M_PWM2) && at_bot));
        match_ev = adv && !sup && (cnt == act);
    end

    // Holding buffer captures every software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (wr_buf) hold_q <= wr_val;
    end

    // Live compare value: direct write or copy at the update point.
    always_ff @(posedge clk) begin
        if (!rst_n)                 act <= '0;
        else if (wr_buf && direct)  act <= wr_val;
        else if (load_pt)           act <= hold_q;
    end

    // Waveform shaping per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else begin
            case (mode)
                M_NORM, M_CTC: if (match_ev) wave <= !wave;
                M_PWM1: begin
                    if (adv && at_top) wave <= 1'b1;
                    else if (match_ev) wave <= 1'b0;
                end
                default: if (match_ev) wave <= down;
            endcase
        end
    end
endmodule

// File: rtl/tmr_flags.sv
// Sticky event flags with write-one-to-clear, mask register and combined
// interrupt request. A set event wins over a clear in the same cycle.
module tmr_flags #(
    parameter int unsigned NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_ev,
    input  logic          clr_wr,
    input  logic          mask_wr,
    input  logic [NF-1:0] wr_val,
    output logic [NF-1:0] flags,
    output logic          irq
);
    logic [NF-1:0] mask_q;

    // Flag register: clear by written ones, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~(clr_wr ? wr_val : '0)) | set_ev;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wr_val;
    end

    // Interrupt request from enabled flags.
    always_comb irq = |(flags & mask_q);
endmodule

// File: rtl/tmr8_updown.sv
// Top of the bidirectional timer: register write decode, tick source
// selection, counter engine, two compare channels and flag logic.
// Assumes both tick strobes are one clock wide and synchronous to clk.
module tmr8_updown
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          ext_tick_i,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    output logic [W-1:0]  count_o,
    output logic [2:0]    flags_o,
    output logic [1:0]    wave_o,
    output logic          irq_o
);
    localparam logic [W-1:0] MAXV = '1;

    tmr_mode_e             mode_q;
    logic                  run_q;
    logic                  ext_q;
    logic                  sup_q;
    logic                  qtick;
    logic                  ctrl_wr;
    logic                  cnt_wr;
    logic [W-1:0]          top_w;
    logic                  down_w;
    logic                  adv_w;
    logic                  at_top_w;
    logic                  at_bot_w;
    logic                  ovf_w;
    logic [NCH-1:0][W-1:0] act_w;
    logic [NCH-1:0]        match_w;
    logic [NCH-1:0]        wave_w;

    // Write decode and tick qualification.
    always_comb begin
        ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
        cnt_wr  = wr_en_i && (wr_addr_i == A_CNT);
        qtick   = run_q && (ext_q ? ext_tick_i : tick_i);
        top_w   = (mode_q == M_CTC) ? act_w[0] : MAXV;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_NORM;
            run_q  <= 1'b0;
            ext_q  <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q <= tmr_mode_e'(wr_data_i[1:0]);
            run_q  <= wr_data_i[2];
            ext_q  <= wr_data_i[3];
        end
    end

    // Match suppression after a count write, consumed by the next advance.
    always_ff @(posedge clk) begin
        if (!rst_n)     sup_q <= 1'b0;
        else if (cnt_wr) sup_q <= 1'b1;
        else if (adv_w)  sup_q <= 1'b0;
    end

    tmr_core #(.W(W)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (qtick),
        .mode    (mode_q),
        .top     (top_w),
        .ld      (cnt_wr),
        .ld_val  (wr_data_i),
        .dir_rst (ctrl_wr),
        .cnt     (count_o),
        .down    (down_w),
        .adv     (adv_w),
        .at_top  (at_top_w),
        .at_bot  (at_bot_w),
        .ovf_ev  (ovf_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic wr_sel;
        assign wr_sel = wr_en_i && (wr_addr_i == (A_CMPA + 3'(g)));
        tmr_chan #(.W(W)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (adv_w),
            .sup      (sup_q),
            .mode     (mode_q),
            .cnt      (count_o),
            .at_top   (at_top_w),
            .at_bot   (at_bot_w),
            .down     (down_w),
            .wr_buf   (wr_sel),
            .wr_val   (wr_data_i),
            .act      (act_w[g]),
            .match_ev (match_w[g]),
            .wave     (wave_w[g])
        );
    end

    tmr_flags #(.NF(NFLAG)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  ({match_w[1], match_w[0], ovf_w}),
        .clr_wr  (wr_en_i && (wr_addr_i == A_FLAG)),
        .mask_wr (wr_en_i && (wr_addr_i == A_MASK)),
        .wr_val  (wr_data_i[NFLAG-1:0]),
        .flags   (flags_o),
        .irq     (irq_o)
    );

    assign wave_o = wave_w;
endmodule

// File: rtl/tmr8_updown_chk.sv
// Temporal checks on the timer, bound to the top module.
module tmr8_updown_chk
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         qtick,
    input logic [1:0]   mode,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] act_a,
    input logic [W-1:0] count,
    input logic [2:0]   flags
);
    localparam logic [W-1:0] MAXV = '1;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!qtick && !(wr_en && wr_addr == A_CNT)) |=> $stable(count));

    // R2
    no_ovf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qtick |=> !$rose(flags[0]));

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qtick && !wr_en && mode == M_NORM && count == MAXV)
        |=> (count == '0 && flags[0]));

    // R5
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qtick && !wr_en && mode == M_CTC && count == act_a) |=> count == '0);

    // R10
    dual_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qtick && !wr_en && mode == M_PWM2 && count == MAXV)
        |=> count == MAXV - W'(1));

    for (genvar i = 0; i < 3; i++) begin : g_stk
        // R12
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(wr_en && wr_addr == A_FLAG && wr_data[i])) |=> flags[i]);
    end
endmodule

bind tmr8_updown tmr8_updown_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .qtick   (qtick),
    .mode    (mode_q),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .act_a   (act_w[0]),
    .count   (count_o),
    .flags   (flags_o)
);

// File: tb/tmr8_updown_tb_top.sv
`timescale 1ns/1ps
module tmr8_updown_tb_top;
    import tmr_pkg::*;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       ext_tick_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count;
    logic [2:0] flags;
    logic [1:0] wave;
    logic       irq;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;

    always #4 clk = !clk;

    tmr8_updown #(.W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .ext_tick_i (ext_tick_i),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .count_o    (count),
        .flags_o    (flags),
        .wave_o     (wave),
        .irq_o      (irq)
    );

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.sel)
                0: act = count;
                1: act = {5'b0, flags};
                2: act = {6'b0, wave};
                default: act = {7'b0, irq};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_v(input string r, input int sel, input logic [7:0] e);
        item_t it;
        it.req = r; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic tk(input bit ext);
        @(negedge clk);
        tick_i = !ext; ext_tick_i = ext;
        @(posedge clk); #1;
        tick_i = 1'b0; ext_tick_i = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        expect_v("R1", 0, 8'h00); expect_v("R1", 1, 8'h0);
        expect_v("R1", 2, 8'h0);  expect_v("R1", 3, 8'h0);

        // R2 stopped: ticks ignored
        for (int i = 0; i < 3; i++) tk(0);
        expect_v("R2", 0, 8'h00); expect_v("R2", 1, 8'h0);

        // R8 direct compare writes in mode 0
        wr(A_CTRL, 8'h04); wr(A_CMPA, 8'h40); wr(A_CMPB, 8'h50);

        // R4 wrap and overflow
        wr(A_CNT, 8'hFD); tk(0); tk(0);
        expect_v("R4", 0, 8'hFF); expect_v("R4", 1, 8'h0);
        tk(0);
        expect_v("R4", 0, 8'h00); expect_v("R4", 1, 8'h1);

        // R12 mask, irq, clear
        wr(A_MASK, 8'h01); expect_v("R12", 3, 8'h1);
        wr(A_MASK, 8'h00); expect_v("R12", 3, 8'h0);
        wr(A_FLAG, 8'h01); expect_v("R12", 1, 8'h0);

        // R3 external source
        wr(A_CTRL, 8'h0C); tk(0); tk(0);
        expect_v("R3", 0, 8'h00);
        tk(1); tk(1);
        expect_v("R3", 0, 8'h02);
        wr(A_CTRL, 8'h04);

        // R7 suppression after count write
        wr(A_CNT, 8'h50); tk(0);
        expect_v("R7", 0, 8'h51); expect_v("R7", 1, 8'h0); expect_v("R7", 2, 8'h0);
        // R6 match and toggle
        wr(A_CNT, 8'h4F); tk(0); tk(0);
        expect_v("R6", 0, 8'h51); expect_v("R6", 1, 8'h4); expect_v("R6", 2, 8'h2);
        wr(A_FLAG, 8'h04);

        // R5 clear on compare A
        wr(A_CMPA, 8'h03); wr(A_CTRL, 8'h05); wr(A_CNT, 8'h00);
        tk(0); tk(0); tk(0);
        expect_v("R5", 0, 8'h03);
        tk(0);
        expect_v("R5", 0, 8'h00); expect_v("R5", 1, 8'h2); expect_v("R6", 2, 8'h3);
        tk(0);
        expect_v("R5", 0, 8'h01);
        wr(A_FLAG, 8'h07);

        // R8 / R9 single-slope with buffered compare
        wr(A_CTRL, 8'h04); wr(A_CMPA, 8'h10); wr(A_CTRL, 8'h06); wr(A_CMPA, 8'h20);
        wr(A_CNT, 8'h0F); tk(0); tk(0);
        expect_v("R8", 0, 8'h11); expect_v("R8", 1, 8'h2); expect_v("R9", 2, 8'h2);
        wr(A_FLAG, 8'h07);
        wr(A_CNT, 8'hFE); tk(0); tk(0);
        expect_v("R9", 0, 8'h00); expect_v("R9", 2, 8'h3); expect_v("R4", 1, 8'h1);
        wr(A_FLAG, 8'h07);
        wr(A_CNT, 8'h0F); tk(0); tk(0);
        expect_v("R8", 1, 8'h0); expect_v("R8", 2, 8'h3);
        wr(A_CNT, 8'h1F); tk(0); tk(0);
        expect_v("R9", 0, 8'h21); expect_v("R9", 1, 8'h2); expect_v("R9", 2, 8'h2);
        wr(A_FLAG, 8'h07);

        // R10 / R11 dual-slope
        wr(A_CTRL, 8'h07); wr(A_CMPB, 8'hFD);
        wr(A_CNT, 8'h00); tk(0);
        expect_v("R10", 0, 8'h01); expect_v("R10", 1, 8'h1);
        wr(A_FLAG, 8'h07);
        wr(A_CNT, 8'hFC); tk(0); tk(0);
        expect_v("R11", 0, 8'hFE); expect_v("R11", 1, 8'h4); expect_v("R11", 2, 8'h0);
        wr(A_FLAG, 8'h07);
        tk(0); tk(0);
        expect_v("R10", 0, 8'hFE);
        tk(0); tk(0);
        expect_v("R11", 0, 8'hFC); expect_v("R11", 2, 8'h2); expect_v("R11", 1, 8'h4);
        wr(A_FLAG, 8'h07);
        wr(A_CNT, 8'h02); tk(0); tk(0); tk(0);
        expect_v("R10", 0, 8'h01); expect_v("R10", 1, 8'h1);

        // R2 run bit cleared in mode 3
        wr(A_CTRL, 8'h03); tk(0); tk(0);
        expect_v("R2", 0, 8'h01); expect_v("R2", 1, 8'h1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule